// File: doc/BRIEF.md
# SCL Low-Time Watchdog Timer

This block watches the clock line of a two-wire serial bus and reports when it has been held low for too long. A target that stalls or stretches the clock past the allowed time is flagged this way. The core clock first passes through a power-of-two divider. A 4-bit field gives the divider as a base-2 logarithm. The divided ticks advance a 15-bit counter, and that count is compared against a programmed limit. When the count reaches the limit, a single-cycle pulse is produced. This pulse is meant to set the timeout flag in the bus master's status logic.

The clock-line input must already be synchronized to the core clock. The divider and counter start from zero on every new low phase. This means the measured time is always the length of the current low phase and never a sum of earlier ones. An enable input gates the whole function. A limit of zero also turns detection off. With a 15-bit limit and a divider of up to 2^15, timeouts in the tens of milliseconds fit in a small counter. For example, a 25 ms target needs software to choose the smallest divider that brings the limit under 2^15. If no divider does, software saturates the limit at 0x7FFF.

All pins are plain level-type control and status signals. No data stream passes through the block, so it has no handshake.

Top module: `scl_low_watchdog`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `timeout_pulse` is 0.
- R2: With `div_log2` = 0 and a non-zero `limit` L, the pulse is first high in the (L+1)-th cycle after `scl_in` goes low. Cycles are counted as rising edges that sample `scl_in` = 0.
- R3: The counter advances once every 2^N core clocks, where N is `div_log2` (0..15). The pulse is first high after L*2^N+1 low edges.
- R4: The pulse is exactly one cycle wide. It does not fire again while `scl_in` stays low, even when the low phase continues far past the limit.
- R5: Whenever `scl_in` is high, the counter and the divider clear. A low phase shorter than the limit, followed by a high phase, does not carry its count into the next low phase.
- R6: While `enable` is 0, the pulse stays 0 and the counter and divider stay cleared. Setting `enable` during a low phase starts the measurement from zero at that point.
- R7: A `limit` of 0 never produces a pulse, even with `enable` set.
- R8: After a pulse, a high phase on `scl_in` re-arms detection. The next sufficiently long low phase pulses again.
- R9: The extreme settings work: `limit` = 0x7FFF with N = 0 pulses after 32768 low edges, and `limit` = 1 with N = 15 pulses after 32769.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Synchronized clock-line level (0 = low) |
| enable | input | 1 | Enables the watchdog; 0 clears and holds it idle |
| div_log2 | input | 4 | Divider exponent N; the count advances every 2^N clocks |
| limit | input | 15 | Count at which the timeout fires; 0 turns detection off |
| timeout_pulse | output | 1 | One-cycle pulse when the low time reaches the limit |

## Verification
The hardest conditions to reach from the ports are the extreme divider and limit settings. Each one needs tens of thousands of unbroken low cycles before a single pulse appears. The stimulus holds the line low across those spans, counts every edge, and checks that exactly one pulse appears on the predicted edge. The second difficult case is turning `enable` on in the middle of an already long low phase. That stimulus is applied with the line held low, so that the restart from zero can be told apart from a count carried over from before.

// File: rtl/scl_wdt_pkg.sv
package scl_wdt_pkg;
  localparam int CNT_W = 15;
  localparam int PRE_W = 4;
  localparam int DIV_W = (1 << PRE_W) - 1;
  typedef logic [CNT_W-1:0] low_count_t;
endpackage

// File: rtl/scl_wdt_prescaler.sv
module scl_wdt_prescaler #(
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [PRE_W-1:0] log2_div,
  output logic             tick
);
  localparam int DIV_W = (1 << PRE_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    mask = ~({DIV_W{1'b1}} << log2_div);
    tick = !clear && ((div_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      div_q <= '0;
    else if (clear || tick)
      div_q <= '0;
    else
      div_q <= div_q + 1'b1;
  end

  // R5
  div_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (div_q == '0));
endmodule

// File: rtl/scl_wdt_counter.sv
module scl_wdt_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (clear)
      count <= '0;
    else if (tick && (count != {CNT_W{1'b1}}))
      count <= count + 1'b1;
  end

  // R5
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0));

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (count == $past(count)) || (count == $past(count) + 1'b1));
endmodule

// File: rtl/scl_wdt_expiry.sv
module scl_wdt_expiry #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] limit,
  output logic             pulse
);
  logic fired_q;
  logic hit;

  always_comb hit = !clear && (limit != '0) && (count == limit) && !fired_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fired_q <= 1'b0;
      pulse   <= 1'b0;
    end else begin
      pulse <= hit;
      if (clear)
        fired_q <= 1'b0;
      else if (hit)
        fired_q <= 1'b1;
    end
  end

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

  // R7
  zero_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> ($past(limit) != '0));
endmodule

// File: rtl/scl_low_watchdog.sv
module scl_low_watchdog
  import scl_wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             enable,
  input  logic [PRE_W-1:0] div_log2,
  input  logic [CNT_W-1:0] limit,
  output logic             timeout_pulse
);
  logic       clear;
  logic       tick;
  low_count_t low_count;

  always_comb clear = scl_in || !enable;

  scl_wdt_prescaler #(.PRE_W(PRE_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .log2_div (div_log2),
    .tick     (tick)
  );

  scl_wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear),
    .tick  (tick),
    .count (low_count)
  );

  scl_wdt_expiry #(.CNT_W(CNT_W)) u_exp (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear),
    .count (low_count),
    .limit (limit),
    .pulse (timeout_pulse)
  );

  // R5
  high_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |-> !$past(scl_in));

  // R6
  disabled_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !timeout_pulse);
endmodule

// File: tb/scl_low_watchdog_test.sv
module scl_low_watchdog_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_in = 1'b1;
  logic        enable = 1'b0;
  logic [3:0]  div_log2 = '0;
  logic [14:0] limit = '0;
  logic        timeout_pulse;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_low_watchdog uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .enable(enable),
    .div_log2(div_log2), .limit(limit), .timeout_pulse(timeout_pulse)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure(input int cycles, output int first, output int npulse);
    first = 0;
    npulse = 0;
    for (int i = 1; i <= cycles; i++) begin
      @(negedge clk);
      if (timeout_pulse) begin
        if (npulse == 0) first = i;
        npulse++;
      end
    end
  endtask

  task automatic go_high(input int cycles);
    @(negedge clk);
    scl_in = 1'b1;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic low_run(input string req, input int n, input int lim, input int exp_first);
    int first, np;
    go_high(2);
    div_log2 = n[3:0];
    limit = lim[14:0];
    enable = 1'b1;
    scl_in = 1'b0;
    measure(exp_first + 20, first, np);
    check(req, first, exp_first);
    check(req, np, 1);
  endtask

  task automatic t_reset();
    scl_in = 1'b0;
    enable = 1'b1;
    limit = 15'd1;
    repeat (4) @(negedge clk);
    check("R1", int'(timeout_pulse), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(timeout_pulse), 0);
  endtask

  task automatic t_basic();
    low_run("R2", 0, 5, 6);
  endtask

  task automatic t_prescale();
    low_run("R3", 3, 4, 33);
  endtask

  task automatic t_long_hold();
    int first, np;
    go_high(2);
    div_log2 = 4'd0;
    limit = 15'd3;
    scl_in = 1'b0;
    measure(300, first, np);
    check("R4", first, 4);
    check("R4", np, 1);
  endtask

  task automatic t_short_low();
    int first, np;
    go_high(2);
    div_log2 = 4'd0;
    limit = 15'd10;
    scl_in = 1'b0;
    measure(8, first, np);
    check("R5", np, 0);
    scl_in = 1'b1;
    repeat (2) @(negedge clk);
    scl_in = 1'b0;
    measure(30, first, np);
    check("R5", first, 11);
    check("R5", np, 1);
  endtask

  task automatic t_enable();
    int first, np;
    go_high(2);
    enable = 1'b0;
    div_log2 = 4'd0;
    limit = 15'd3;
    scl_in = 1'b0;
    measure(50, first, np);
    check("R6", np, 0);
    enable = 1'b1;
    measure(20, first, np);
    check("R6", first, 4);
    check("R6", np, 1);
  endtask

  task automatic t_zero_limit();
    int first, np;
    go_high(2);
    div_log2 = 4'd0;
    limit = 15'd0;
    scl_in = 1'b0;
    measure(100, first, np);
    check("R7", np, 0);
  endtask

  task automatic t_rearm();
    int first, np;
    go_high(2);
    div_log2 = 4'd0;
    limit = 15'd2;
    scl_in = 1'b0;
    measure(10, first, np);
    check("R8", first, 3);
    scl_in = 1'b1;
    @(negedge clk);
    scl_in = 1'b0;
    measure(10, first, np);
    check("R8", first, 3);
    check("R8", np, 1);
  endtask

  task automatic t_extremes();
    low_run("R9", 0, 32767, 32768);
    low_run("R9", 15, 1, 32769);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_basic();
        t_prescale();
        t_long_hold();
        t_short_low();
        t_enable();
        t_zero_limit();
        t_rearm();
        t_extremes();
        done = 1;
      end
      begin
        repeat (190000) @(posedge clk);
        if (!done) begin
          checks++;
          fails++;
          $display("FAIL watchdog: actual hung expected finished");
        end
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule